// File: doc/BRIEF.md
# Slave-Port Bus Arbiter with Parking

This block decides which of up to sixteen bus masters owns one slave port of a multi-master interconnect. Every cycle it looks at the request lines and at the transfer state of the master that currently owns the slave. It is allowed to hand the slave to another master only at an arbitration point. These points are: no owner, an idle owner, a single-beat transfer, the final beat of a burst, and the expiry of a programmable slot timer that stops one master from holding the slave through a very long burst.

At an arbitration point with requests pending, the winner is chosen either by rotating priority or by fixed index priority. With no request pending, a parking policy takes over. The slave can be released, left with its last owner, or handed to a programmed master. The grant is registered. It appears as a one-hot vector, a binary index and a valid flag. The interconnect uses these to steer its address and data multiplexers.

Top module: `slv_arb`

## Requirements
- R1: While reset is asserted, and until the first request is granted after reset, `gnt_vld_o` is 0 and `gnt_o` is all zeros.
- R2: `gnt_o` has at most one bit set. When `gnt_vld_o` is 1, exactly bit `gnt_idx_o` is set.
- R3: The owner changes only at an arbitration point. That is a cycle in which there is no owner, or the owner's `act_i` bit is 0, or its `single_i` bit is 1, or its `last_i` bit is 1, or its slot timer expires. At any other cycle the grant holds, even when other masters request.
- R4: With `sched_i` = 1 (fixed priority), the requesting master with the lowest index wins an arbitration point.
- R5: With `sched_i` = 0 (rotating, the intended reset setting), the search starts at the index after the master most recently granted through a request and wraps around. After reset the search starts at index 0. Parking does not move the search start.
- R6: With `park_type_i` = 00 or 11, an arbitration point with no request drops the grant (`gnt_vld_o` = 0).
- R7: With `park_type_i` = 01, an arbitration point with no request keeps the current grant, or keeps no grant if there was none.
- R8: With `park_type_i` = 10, an arbitration point with no request grants master `park_mst_i`. The parked master follows a rewrite of `park_mst_i` at the next such point.
- R9: At every arbitration point the slot timer loads `slot_lim_i`. With a loaded value L > 0, the L-th active beat of the owner after that point is itself an arbitration point.
- R10: A loaded slot value of 0 disables the timer, so a burst with no end indication is never broken.
- R11: A decision made at an arbitration point appears on the outputs one clock after that cycle. The outputs never follow the inputs within the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_i | input | N_MST | Request line per master |
| act_i | input | N_MST | Master is performing a transfer on this slave this cycle |
| single_i | input | N_MST | Master's current transfer is a single beat |
| last_i | input | N_MST | Master's current beat is the last of its burst |
| sched_i | input | 1 | 0 rotating priority, 1 fixed priority |
| park_type_i | input | 2 | 00 none, 01 last owner, 10 fixed master, 11 none |
| park_mst_i | input | IDX_W | Master parked on in fixed parking |
| slot_lim_i | input | SLOT_W | Slot timer length in beats, 0 disables |
| gnt_o | output | N_MST | One-hot grant |
| gnt_idx_o | output | IDX_W | Index of the granted master |
| gnt_vld_o | output | 1 | A master is granted |

## Verification
Wrong arbitration-point logic shows up as a grant that moves in the middle of a burst, or one that stays put after the last beat. Either is visible on `gnt_o` in the cycle that follows. A rotation pointer that has gone bad stays hidden until two or more masters contend. Then it picks the wrong winner at the very next arbitration point. A slot timer that is off by one moves the break of a long burst by exactly one beat, so the bench compares the grant on every cycle against a model kept from the requirements, and directed bursts are timed to the beat.

// File: rtl/slv_arb_pkg.sv
package slv_arb_pkg;

  typedef enum logic [1:0] {
    PARK_NONE  = 2'b00,
    PARK_LAST  = 2'b01,
    PARK_FIXED = 2'b10,
    PARK_RSVD  = 2'b11
  } park_e;

  typedef enum logic {
    SCH_ROTATE = 1'b0,
    SCH_PRIO   = 1'b1
  } sched_e;

endpackage

// File: rtl/slv_arb_rst_sync.sv
module slv_arb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_q = sync_q[STAGES-1];

endmodule

// File: rtl/slv_arb_pick.sv
module slv_arb_pick #(
  parameter int N_MST = 16,
  parameter int IDX_W = $clog2(N_MST)
) (
  input  logic [N_MST-1:0] req,
  input  logic [IDX_W-1:0] ptr,
  input  logic             sched,
  output logic             any,
  output logic [IDX_W-1:0] sel
);

  logic [IDX_W-1:0] rot_sel;
  logic [IDX_W-1:0] pri_sel;
  logic             rot_found;

  // rotating search: begins one past the pointer and wraps
  always_comb begin
    rot_sel   = '0;
    rot_found = 1'b0;
    for (int k = 1; k <= N_MST; k++) begin
      if (!rot_found && req[(int'(ptr) + k) % N_MST]) begin
        rot_found = 1'b1;
        rot_sel   = IDX_W'((int'(ptr) + k) % N_MST);
      end
    end
  end

  // fixed priority: the lowest index wins
  always_comb begin
    pri_sel = '0;
    for (int k = N_MST - 1; k >= 0; k--) begin
      if (req[k]) begin
        pri_sel = IDX_W'(k);
      end
    end
  end

  assign any = |req;
  assign sel = sched ? pri_sel : rot_sel;

endmodule

// File: rtl/slv_arb_point.sv
module slv_arb_point #(
  parameter int N_MST  = 16,
  parameter int IDX_W  = $clog2(N_MST),
  parameter int SLOT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              own_vld,
  input  logic [IDX_W-1:0]  own_idx,
  input  logic [N_MST-1:0]  act,
  input  logic [N_MST-1:0]  single,
  input  logic [N_MST-1:0]  last,
  input  logic [SLOT_W-1:0] slot_lim,
  output logic              arb_pt,
  output logic              slot_hit
);

  logic [SLOT_W-1:0] cnt_q;
  logic [SLOT_W-1:0] cnt_d;
  logic              cnt_en;
  logic              own_act;
  logic              own_sgl;
  logic              own_lst;

  assign own_act = act[own_idx];
  assign own_sgl = single[own_idx];
  assign own_lst = last[own_idx];

  // a loaded zero never reaches one, so the timer stays off
  assign slot_hit = (cnt_q == SLOT_W'(1));

  assign arb_pt = !own_vld || !own_act || own_sgl || own_lst || slot_hit;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (arb_pt) begin
      cnt_d  = slot_lim;
      cnt_en = 1'b1;
    end else if (cnt_q > SLOT_W'(1)) begin
      cnt_d  = cnt_q - SLOT_W'(1);
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/slv_arb.sv
module slv_arb
  import slv_arb_pkg::*;
#(
  parameter int N_MST  = 16,
  parameter int IDX_W  = $clog2(N_MST),
  parameter int SLOT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_MST-1:0]  req_i,
  input  logic [N_MST-1:0]  act_i,
  input  logic [N_MST-1:0]  single_i,
  input  logic [N_MST-1:0]  last_i,
  input  logic              sched_i,
  input  logic [1:0]        park_type_i,
  input  logic [IDX_W-1:0]  park_mst_i,
  input  logic [SLOT_W-1:0] slot_lim_i,
  output logic [N_MST-1:0]  gnt_o,
  output logic [IDX_W-1:0]  gnt_idx_o,
  output logic              gnt_vld_o
);

  localparam logic [IDX_W-1:0] PTR_RST = IDX_W'(N_MST - 1);

  logic             rst_q;
  logic [IDX_W-1:0] own_idx_q, own_idx_d;
  logic             own_vld_q, own_vld_d;
  logic [IDX_W-1:0] rr_ptr_q, rr_ptr_d;
  logic             own_en;
  logic             arb_pt;
  logic             slot_hit;
  logic             req_any;
  logic [IDX_W-1:0] req_sel;
  park_e            park;

  assign park = park_e'(park_type_i);

  slv_arb_rst_sync #(.STAGES(2)) u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .rst_q (rst_q)
  );

  slv_arb_pick #(.N_MST(N_MST), .IDX_W(IDX_W)) u_pick (
    .req   (req_i),
    .ptr   (rr_ptr_q),
    .sched (sched_i),
    .any   (req_any),
    .sel   (req_sel)
  );

  slv_arb_point #(.N_MST(N_MST), .IDX_W(IDX_W), .SLOT_W(SLOT_W)) u_point (
    .clk      (clk),
    .rst_n    (rst_q),
    .own_vld  (own_vld_q),
    .own_idx  (own_idx_q),
    .act      (act_i),
    .single   (single_i),
    .last     (last_i),
    .slot_lim (slot_lim_i),
    .arb_pt   (arb_pt),
    .slot_hit (slot_hit)
  );

  // next owner, decided only at an arbitration point
  always_comb begin
    own_idx_d = own_idx_q;
    own_vld_d = own_vld_q;
    rr_ptr_d  = rr_ptr_q;
    own_en    = arb_pt;
    if (arb_pt) begin
      if (req_any) begin
        own_vld_d = 1'b1;
        own_idx_d = req_sel;
        rr_ptr_d  = req_sel;
      end else begin
        unique case (park)
          PARK_LAST: begin
            own_vld_d = own_vld_q;
          end
          PARK_FIXED: begin
            own_vld_d = 1'b1;
            own_idx_d = park_mst_i;
          end
          default: begin
            own_vld_d = 1'b0;
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      own_idx_q <= '0;
      own_vld_q <= 1'b0;
      rr_ptr_q  <= PTR_RST;
    end else if (own_en) begin
      own_idx_q <= own_idx_d;
      own_vld_q <= own_vld_d;
      rr_ptr_q  <= rr_ptr_d;
    end
  end

  for (genvar g = 0; g < N_MST; g++) begin : g_dec
    assign gnt_o[g] = own_vld_q && (own_idx_q == IDX_W'(g));
  end

  assign gnt_idx_o = own_idx_q;
  assign gnt_vld_o = own_vld_q;

endmodule

// File: rtl/slv_arb_chk.sv
module slv_arb_chk #(
  parameter int N_MST = 16,
  parameter int IDX_W = $clog2(N_MST)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_MST-1:0] req_i,
  input logic             sched_i,
  input logic [1:0]       park_type_i,
  input logic [IDX_W-1:0] park_mst_i,
  input logic             arb_pt,
  input logic [N_MST-1:0] gnt_o,
  input logic [IDX_W-1:0] gnt_idx_o,
  input logic             gnt_vld_o
);

  // R2
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_o) && (!gnt_vld_o || gnt_o[gnt_idx_o]));

  // R3
  hold_outside_point_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !arb_pt |=> $stable(gnt_o));

  // R4
  lowest_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_pt && sched_i && (req_i != '0))
      |=> (gnt_o == ($past(req_i) & (~$past(req_i) + N_MST'(1)))));

  // R6
  park_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_pt && (req_i == '0) && (park_type_i == 2'b00 || park_type_i == 2'b11))
      |=> !gnt_vld_o);

  // R7
  park_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_pt && (req_i == '0) && (park_type_i == 2'b01)) |=> $stable(gnt_o));

  // R8
  park_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_pt && (req_i == '0) && (park_type_i == 2'b10))
      |=> (gnt_vld_o && gnt_idx_o == $past(park_mst_i)));

endmodule

bind slv_arb slv_arb_chk #(.N_MST(N_MST), .IDX_W(IDX_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_q),
  .req_i       (req_i),
  .sched_i     (sched_i),
  .park_type_i (park_type_i),
  .park_mst_i  (park_mst_i),
  .arb_pt      (arb_pt),
  .gnt_o       (gnt_o),
  .gnt_idx_o   (gnt_idx_o),
  .gnt_vld_o   (gnt_vld_o)
);

// File: tb/slv_arb_test.sv
`timescale 1ns/1ps
module slv_arb_test;

  localparam int N = 16;

  logic          clk;
  logic          rst_n;
  logic [N-1:0]  req, act, sgl, lst;
  logic          sched;
  logic [1:0]    park;
  logic [3:0]    pmst;
  logic [7:0]    lim;
  logic [N-1:0]  gnt;
  logic [3:0]    gidx;
  logic          gvld;

  int checks = 0;
  int errors = 0;

  // reference state
  logic          m_v;
  int            m_i, m_p, m_c;

  slv_arb uut (
    .clk(clk), .rst_n(rst_n), .req_i(req), .act_i(act), .single_i(sgl),
    .last_i(lst), .sched_i(sched), .park_type_i(park), .park_mst_i(pmst),
    .slot_lim_i(lim), .gnt_o(gnt), .gnt_idx_o(gidx), .gnt_vld_o(gvld)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    summary();
  end

  function automatic logic [N-1:0] exp_vec();
    return m_v ? (N'(1) << m_i) : '0;
  endfunction

  function automatic int pick();
    if (sched) begin
      for (int k = 0; k < N; k++) if (req[k]) return k;
    end else begin
      for (int k = 1; k <= N; k++) if (req[(m_p + k) % N]) return (m_p + k) % N;
    end
    return 0;
  endfunction

  task automatic compare(string tag);
    checks++;
    if (gnt !== exp_vec() || gvld !== m_v || (m_v && gidx !== 4'(m_i))) begin
      errors++;
      $display("FAIL %s: actual gnt=%h vld=%0d idx=%0d expected gnt=%h vld=%0d idx=%0d",
               tag, gnt, gvld, gidx, exp_vec(), m_v, m_i);
    end
  endtask

  // called just after a falling edge with the inputs already applied
  task automatic step(string tag);
    logic ap;
    #0.5;
    compare("R11"); // inputs have no same-cycle effect
    ap = !m_v || !act[m_i] || sgl[m_i] || lst[m_i] || (m_c == 1);
    if (ap) begin
      m_c = int'(lim);
      if (req != '0) begin
        m_i = pick(); m_v = 1'b1; m_p = m_i;
      end else begin
        case (park)
          2'b01: ;
          2'b10: begin m_v = 1'b1; m_i = int'(pmst); end
          default: m_v = 1'b0;
        endcase
      end
    end else if (m_c > 1) begin
      m_c--;
    end
    @(posedge clk);
    @(negedge clk);
    compare(tag);
  endtask

  task automatic drive(logic [N-1:0] r, logic [N-1:0] a, logic [N-1:0] s,
                       logic [N-1:0] l, string tag);
    req = r; act = a; sgl = s; lst = l;
    step(tag);
  endtask

  initial begin
    rst_n = 1'b0; req = '0; act = '0; sgl = '0; lst = '0;
    sched = 1'b0; park = 2'b00; pmst = '0; lim = '0;
    m_v = 1'b0; m_i = 0; m_p = N - 1; m_c = 0;
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    compare("R1");
    rst_n = 1'b1;
    repeat (4) drive('0, '0, '0, '0, "R1");

    // R4 fixed priority, lowest index
    sched = 1'b1;
    drive(16'hA4A4, '0, '0, '0, "R4");
    // R3 burst holds even with a higher-priority request
    repeat (4) drive(16'h0006, 16'h0004, '0, '0, "R3");
    drive(16'h0006, 16'h0004, '0, 16'h0004, "R3");
    // R6 no parking
    drive('0, '0, '0, '0, "R6");
    // R7 park on last owner
    park = 2'b01;
    drive(16'h0010, '0, '0, '0, "R7");
    repeat (2) drive('0, '0, '0, '0, "R7");
    // R8 fixed parking follows a rewrite
    park = 2'b10; pmst = 4'd9;
    drive('0, '0, '0, '0, "R8");
    pmst = 4'd3;
    drive('0, '0, '0, '0, "R8");
    // R5 rotation after last requested grant (4)
    sched = 1'b0; park = 2'b00;
    drive(16'h0092, '0, '0, '0, "R5");
    drive(16'h0092, '0, '0, '0, "R5");
    drive(16'h0092, '0, '0, '0, "R5");
    // R9 slot limit breaks a burst on its third beat
    sched = 1'b1; lim = 8'd3;
    drive(16'h0020, '0, '0, '0, "R9");
    repeat (4) drive(16'h0021, 16'h0020, '0, '0, "R9");
    // R10 limit zero: long burst never broken
    lim = 8'd0;
    drive(16'h0040, '0, '0, '0, "R10");
    repeat (20) drive(16'h0041, 16'h0040, '0, '0, "R10");
    // single-beat transfers are points
    drive(16'h0041, 16'h0040, 16'h0040, '0, "R3");

    // constrained random
    for (int n = 0; n < 4000; n++) begin
      logic [N-1:0] r, a, s, l;
      if (($urandom % 16) == 0) begin
        sched = 1'($urandom); park = 2'($urandom); pmst = 4'($urandom);
        lim = 8'($urandom % 6);
      end
      r = N'($urandom) & N'($urandom);
      a = N'($urandom) | N'($urandom);
      s = N'($urandom) & N'($urandom) & N'($urandom);
      l = N'($urandom) & N'($urandom) & N'($urandom);
      drive(r, a, s, l, "R2");
    end
    summary();
  end

endmodule